// File: doc/BRIEF.md
# Write-Back Buffer with Fill Snooping

This block holds dirty cache lines that have been evicted and are waiting to be written to memory. Each entry carries the set index, the tag and a whole line of data. The entries drain to memory oldest first. The block owns the cache's only memory request port, and it shares that port between its own write-backs and the line-fill reads that the miss tracker asks for.

A fill request is first looked up in the buffer. If the same line is held there, the data of the most recently buffered copy is returned straight to the fill path, and no memory read is issued. The forwarded entry stays in the buffer and is still written back later, so memory receives the data in the end.

The buffer reports how many entries it holds and whether it is full. Core-side logic uses the full flag to stop taking new requests. An eviction offered while the buffer is full is dropped, and an error pulse follows.

Top module: `wb_snoop_buffer`

## Requirements
- R1: After reset the buffer is empty: `buf_count` is 0, `buf_full`, `buf_overflow`, `mem_req_valid` and `fwd_valid` are 0, and `fill_ready` is 1.
- R2: An eviction offered while the buffer is not full is stored, and `buf_count` rises by one on the next cycle, or stays level if an entry drains on the same edge. `buf_full` is 1 exactly when `buf_count` equals DEPTH, and it is the signal that stalls new core requests.
- R3: An eviction offered while `buf_full` is 1 is discarded. On the next cycle `buf_overflow` pulses high for one cycle, and the count is not raised by the dropped line.
- R4: Write-backs leave in arrival order with `mem_req_write`=1, carrying the buffered index, tag and full line data.
- R5: At most one memory request is outstanding. Its outputs hold steady until a cycle in which `mem_ack` is 1. After the acknowledgement of a write-back, that entry leaves the buffer and `buf_count` falls on the next cycle.
- R6: `fill_ready` is 1 only while no memory request is outstanding. A fill offered when the port is free is taken ahead of any write-back in that cycle.
- R7: A taken fill that matches no buffered entry becomes, on the next cycle, a read request with `mem_req_write`=0 and the fill's index and tag.
- R8: A taken fill whose index and tag match a buffered entry raises `fwd_valid` on the next cycle, with the data of the most recently buffered matching entry. No memory request is issued for that fill.
- R9: An entry that was forwarded stays in the buffer and is written back in its normal turn.
- R10: After an acknowledgement in cycle t, the port is idle in cycle t+1. A fill read may appear at t+2, but a write-back appears no earlier than t+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Offer an evicted dirty line |
| evict_index | input | IDX_W | Set index of the evicted line |
| evict_tag | input | TAG_W | Tag of the evicted line |
| evict_data | input | LINE_W | Line data of the evicted line |
| buf_full | output | 1 | Buffer at DEPTH entries; stalls the core |
| buf_count | output | CNT_W | Number of buffered entries |
| buf_overflow | output | 1 | One-cycle pulse after an eviction was dropped |
| fill_valid | input | 1 | Miss tracker requests a line fill |
| fill_index | input | IDX_W | Set index of the requested line |
| fill_tag | input | TAG_W | Tag of the requested line |
| fill_ready | output | 1 | Fill request taken this cycle |
| fwd_valid | output | 1 | Forwarded line data valid |
| fwd_data | output | LINE_W | Line data forwarded from the buffer |
| mem_req_valid | output | 1 | Memory request outstanding |
| mem_req_write | output | 1 | 1 for write-back, 0 for fill read |
| mem_req_index | output | IDX_W | Request set index |
| mem_req_tag | output | TAG_W | Request tag |
| mem_req_data | output | LINE_W | Write-back data, zero for reads |
| mem_ack | input | 1 | Memory ends the request phase |

## Verification
The assertions check these rules on every cycle:
- the count never goes past DEPTH;
- an entry is removed only when the buffer holds one;
- an overflow pulse follows a full cycle;
- a request stays stable until it is acknowledged;
- a forward never issues a memory request alongside it;
- the extra idle cycle comes before a write-back that follows an acknowledgement.

The bench's scenarios are the only way to show the data behaviour. That covers which of several matching entries is forwarded, the drain order, and whether the line written back after a forward is the right one. The bench checks these against a queue model driven by random evictions, fills and acknowledgement delays.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    // Occupant of the single memory request port
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_WRITE = 2'd2
    } wbb_port_e;
endpackage

// File: rtl/wbb_store.sv
module wbb_store #(
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int LINE_W = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [IDX_W-1:0]  push_idx_i,
    input  logic [TAG_W-1:0]  push_tag_i,
    input  logic [LINE_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic [IDX_W-1:0]  look_idx_i,
    input  logic [TAG_W-1:0]  look_tag_i,
    output logic              look_hit_o,
    output logic [LINE_W-1:0] look_data_o,
    output logic [IDX_W-1:0]  head_idx_o,
    output logic [TAG_W-1:0]  head_tag_o,
    output logic [LINE_W-1:0] head_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0]  idx;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][LINE_W-1:0] data;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [CNT_W-1:0]             count;
        logic                         ovf;
    } store_t;

    store_t st_d, st_q;

    assign full_o      = (st_q.count == CNT_W'(DEPTH));
    assign count_o     = st_q.count;
    assign overflow_o  = st_q.ovf;
    assign head_idx_o  = st_q.idx[st_q.head];
    assign head_tag_o  = st_q.tag[st_q.head];
    assign head_data_o = st_q.data[st_q.head];

    // Per-slot age (0 = oldest) and match against the lookup key
    logic [DEPTH-1:0][PTR_W-1:0] age;
    logic [DEPTH-1:0]            hit_vec;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        assign age[s]     = PTR_W'(s) - st_q.head;
        assign hit_vec[s] = (CNT_W'(age[s]) < st_q.count)
                          && (st_q.idx[s] == look_idx_i)
                          && (st_q.tag[s] == look_tag_i);
    end

    // Youngest matching slot wins
    logic [PTR_W-1:0] best_slot;
    logic [PTR_W-1:0] best_age;
    logic             found;

    always_comb begin
        found     = 1'b0;
        best_slot = '0;
        best_age  = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (hit_vec[s] && (!found || age[s] > best_age)) begin
                found     = 1'b1;
                best_slot = PTR_W'(s);
                best_age  = age[s];
            end
        end
    end

    assign look_hit_o  = found;
    assign look_data_o = st_q.data[best_slot];

    logic accept;
    assign accept = push_i && !full_o;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = push_i && full_o;
        if (pop_i) begin
            st_d.head = st_q.head + 1'b1;
        end
        if (accept) begin
            st_d.idx[st_q.tail]  = push_idx_i;
            st_d.tag[st_q.tail]  = push_tag_i;
            st_d.data[st_q.tail] = push_data_i;
            st_d.tail            = st_q.tail + 1'b1;
        end
        st_d.count = st_q.count + CNT_W'(accept) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> st_q.count != '0);

    a_r3_overflow_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> $past(full_o));

    a_r3_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/wbb_port.sv
module wbb_port
    import wbb_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic              snoop_hit_i,
    input  logic [LINE_W-1:0] snoop_data_i,
    input  logic              wb_pending_i,
    input  logic [IDX_W-1:0]  head_idx_i,
    input  logic [TAG_W-1:0]  head_tag_i,
    input  logic [LINE_W-1:0] head_data_i,
    input  logic              mem_ack_i,
    output logic              fill_ready_o,
    output logic              fwd_valid_o,
    output logic [LINE_W-1:0] fwd_data_o,
    output logic              mem_valid_o,
    output logic              mem_write_o,
    output logic [IDX_W-1:0]  mem_idx_o,
    output logic [TAG_W-1:0]  mem_tag_o,
    output logic [LINE_W-1:0] mem_data_o,
    output logic              pop_o
);
    typedef struct packed {
        wbb_port_e         kind;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
        logic              ack_seen;
        logic              fwd_v;
        logic [LINE_W-1:0] fwd_data;
    } port_t;

    port_t pt_d, pt_q;

    logic busy, ack, take_fill, launch_wb;

    assign busy         = (pt_q.kind != PORT_IDLE);
    assign ack          = busy && mem_ack_i;
    assign fill_ready_o = !busy;
    assign take_fill    = fill_valid_i && !busy;
    // Fill has priority; a write-back waits one extra cycle after an ack
    assign launch_wb    = !busy && !fill_valid_i && wb_pending_i && !pt_q.ack_seen;
    assign pop_o        = ack && (pt_q.kind == PORT_WRITE);

    always_comb begin
        pt_d          = pt_q;
        pt_d.ack_seen = ack;
        pt_d.fwd_v    = take_fill && snoop_hit_i;
        if (take_fill && snoop_hit_i) begin
            pt_d.fwd_data = snoop_data_i;
        end
        if (ack) begin
            pt_d.kind = PORT_IDLE;
        end else if (take_fill && !snoop_hit_i) begin
            pt_d.kind = PORT_READ;
            pt_d.idx  = fill_idx_i;
            pt_d.tag  = fill_tag_i;
            pt_d.data = '0;
        end else if (launch_wb) begin
            pt_d.kind = PORT_WRITE;
            pt_d.idx  = head_idx_i;
            pt_d.tag  = head_tag_i;
            pt_d.data = head_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign mem_valid_o = busy;
    assign mem_write_o = (pt_q.kind == PORT_WRITE);
    assign mem_idx_o   = pt_q.idx;
    assign mem_tag_o   = pt_q.tag;
    assign mem_data_o  = pt_q.data;
    assign fwd_valid_o = pt_q.fwd_v;
    assign fwd_data_o  = pt_q.fwd_data;

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ack_i) |=> (mem_valid_o && $stable(mem_write_o)
            && $stable(mem_idx_o) && $stable(mem_tag_o) && $stable(mem_data_o)));

    a_r10_wb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ack_i) |=> !mem_valid_o ##1 !(mem_valid_o && mem_write_o));

    a_r8_fwd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> !mem_valid_o);

    a_r7_read_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_write_o && !$past(mem_valid_o))
            |-> $past(fill_valid_i && !snoop_hit_i));
endmodule

// File: rtl/wb_snoop_buffer.sv
module wb_snoop_buffer #(
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int LINE_W = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [IDX_W-1:0]  evict_index,
    input  logic [TAG_W-1:0]  evict_tag,
    input  logic [LINE_W-1:0] evict_data,
    output logic              buf_full,
    output logic [CNT_W-1:0]  buf_count,
    output logic              buf_overflow,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              fill_ready,
    output logic              fwd_valid,
    output logic [LINE_W-1:0] fwd_data,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [IDX_W-1:0]  mem_req_index,
    output logic [TAG_W-1:0]  mem_req_tag,
    output logic [LINE_W-1:0] mem_req_data,
    input  logic              mem_ack
);
    logic              pop, snoop_hit;
    logic [LINE_W-1:0] snoop_data, head_data;
    logic [IDX_W-1:0]  head_idx;
    logic [TAG_W-1:0]  head_tag;

    wbb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (evict_valid),
        .push_idx_i  (evict_index),
        .push_tag_i  (evict_tag),
        .push_data_i (evict_data),
        .pop_i       (pop),
        .look_idx_i  (fill_index),
        .look_tag_i  (fill_tag),
        .look_hit_o  (snoop_hit),
        .look_data_o (snoop_data),
        .head_idx_o  (head_idx),
        .head_tag_o  (head_tag),
        .head_data_o (head_data),
        .count_o     (buf_count),
        .full_o      (buf_full),
        .overflow_o  (buf_overflow)
    );

    wbb_port #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid_i (fill_valid),
        .fill_idx_i   (fill_index),
        .fill_tag_i   (fill_tag),
        .snoop_hit_i  (snoop_hit),
        .snoop_data_i (snoop_data),
        .wb_pending_i (buf_count != '0),
        .head_idx_i   (head_idx),
        .head_tag_i   (head_tag),
        .head_data_i  (head_data),
        .mem_ack_i    (mem_ack),
        .fill_ready_o (fill_ready),
        .fwd_valid_o  (fwd_valid),
        .fwd_data_o   (fwd_data),
        .mem_valid_o  (mem_req_valid),
        .mem_write_o  (mem_req_write),
        .mem_idx_o    (mem_req_index),
        .mem_tag_o    (mem_req_tag),
        .mem_data_o   (mem_req_data),
        .pop_o        (pop)
    );

    a_r2_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !mem_req_valid) |=> buf_count != '0);
endmodule

// File: tb/sim_wb_snoop_buffer.sv
module sim_wb_snoop_buffer;
    localparam int DEPTH    = 4;
    localparam int IDX_W    = 4;
    localparam int TAG_W    = 8;
    localparam int LINE_W   = 64;
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int CLK_HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evict_valid = 1'b0;
    logic [IDX_W-1:0] evict_index = '0;
    logic [TAG_W-1:0] evict_tag = '0;
    logic [LINE_W-1:0] evict_data = '0;
    logic buf_full, buf_overflow, fill_ready, fwd_valid;
    logic [CNT_W-1:0] buf_count;
    logic fill_valid = 1'b0;
    logic [IDX_W-1:0] fill_index = '0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic [LINE_W-1:0] fwd_data, mem_req_data;
    logic mem_req_valid, mem_req_write;
    logic [IDX_W-1:0] mem_req_index;
    logic [TAG_W-1:0] mem_req_tag;
    logic mem_ack = 1'b0;

    always #CLK_HALF clk = ~clk;

    wb_snoop_buffer #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u0 (.*);

    int checks = 0;
    int errors = 0;

    // Reference model
    logic [IDX_W-1:0]  mq_idx [DEPTH];
    logic [TAG_W-1:0]  mq_tag [DEPTH];
    logic [LINE_W-1:0] mq_data[DEPTH];
    int mn = 0;
    int m_kind = 0;   // 0 idle, 1 read, 2 write
    logic [IDX_W-1:0]  m_idx = '0;
    logic [TAG_W-1:0]  m_tag = '0;
    logic [LINE_W-1:0] m_data = '0;
    logic m_ack_seen = 1'b0, m_fwd_v = 1'b0, m_ovf = 1'b0;
    logic [LINE_W-1:0] m_fwd_d = '0;

    task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check_eq("R2", "buf_count", 64'(buf_count), 64'(mn));
        check_eq("R2", "buf_full", 64'(buf_full), 64'(mn == DEPTH));
        check_eq("R3", "buf_overflow", 64'(buf_overflow), 64'(m_ovf));
        check_eq("R6", "fill_ready", 64'(fill_ready), 64'(m_kind == 0));
        check_eq("R5", "mem_req_valid", 64'(mem_req_valid), 64'(m_kind != 0));
        if (m_kind == 2) begin
            check_eq("R4", "wb write", 64'(mem_req_write), 64'd1);
            check_eq("R4", "wb index", 64'(mem_req_index), 64'(m_idx));
            check_eq("R4", "wb tag", 64'(mem_req_tag), 64'(m_tag));
            check_eq("R4", "wb data", 64'(mem_req_data), 64'(m_data));
        end else if (m_kind == 1) begin
            check_eq("R7", "rd write", 64'(mem_req_write), 64'd0);
            check_eq("R7", "rd index", 64'(mem_req_index), 64'(m_idx));
            check_eq("R7", "rd tag", 64'(mem_req_tag), 64'(m_tag));
        end
        check_eq("R8", "fwd_valid", 64'(fwd_valid), 64'(m_fwd_v));
        if (m_fwd_v) check_eq("R8", "fwd_data", 64'(fwd_data), 64'(m_fwd_d));
    endtask

    task automatic step(input logic ev, input logic [IDX_W-1:0] ei, input logic [TAG_W-1:0] et,
                        input logic [LINE_W-1:0] ed, input logic fv, input logic [IDX_W-1:0] fi,
                        input logic [TAG_W-1:0] ft, input logic ack);
        logic busy, a, take, hit, wb, full_now, was_write;
        logic [LINE_W-1:0] hd;
        compare_all();
        evict_valid = ev; evict_index = ei; evict_tag = et; evict_data = ed;
        fill_valid = fv; fill_index = fi; fill_tag = ft; mem_ack = ack;
        busy = (m_kind != 0);
        a = ack && busy;
        take = fv && !busy;
        hit = 1'b0; hd = '0;
        for (int k = 0; k < mn; k++)
            if (mq_idx[k] == fi && mq_tag[k] == ft) begin hit = 1'b1; hd = mq_data[k]; end
        wb = !busy && !fv && (mn != 0) && !m_ack_seen;
        full_now = (mn == DEPTH);
        was_write = (m_kind == 2);
        m_fwd_v = take && hit;
        if (take && hit) m_fwd_d = hd;
        if (a) m_kind = 0;
        else if (take && !hit) begin m_kind = 1; m_idx = fi; m_tag = ft; m_data = '0; end
        else if (wb) begin m_kind = 2; m_idx = mq_idx[0]; m_tag = mq_tag[0]; m_data = mq_data[0]; end
        if (a && was_write) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                mq_idx[k] = mq_idx[k+1]; mq_tag[k] = mq_tag[k+1]; mq_data[k] = mq_data[k+1];
            end
            mn--;
        end
        if (ev && !full_now) begin
            mq_idx[mn] = ei; mq_tag[mn] = et; mq_data[mn] = ed; mn++;
        end
        m_ovf = ev && full_now;
        m_ack_seen = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_step(input logic ack);
        step(1'b0, '0, '0, '0, 1'b0, '0, '0, ack);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_eq("R1", "count", 64'(buf_count), 64'd0);
        check_eq("R1", "full", 64'(buf_full), 64'd0);
        check_eq("R1", "overflow", 64'(buf_overflow), 64'd0);
        check_eq("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        check_eq("R1", "fwd_valid", 64'(fwd_valid), 64'd0);
        check_eq("R1", "fill_ready", 64'(fill_ready), 64'd1);

        // Fill miss goes to memory (R7), buffering two copies of one line
        step(1'b1, 4'd2, 8'd3, 64'h111, 1'b1, 4'd7, 8'd7, 1'b0);
        check_eq("R7", "read issued", 64'({mem_req_valid, mem_req_write}), 64'b10);
        check_eq("R7", "read index", 64'(mem_req_index), 64'd7);
        step(1'b1, 4'd2, 8'd3, 64'h222, 1'b0, '0, '0, 1'b0);
        step(1'b0, '0, '0, '0, 1'b1, 4'd2, 8'd3, 1'b1);
        check_eq("R6", "ready after ack", 64'(fill_ready), 64'd1);
        step(1'b0, '0, '0, '0, 1'b1, 4'd2, 8'd3, 1'b0);
        check_eq("R8", "forward newest", 64'(fwd_data), 64'h222);
        check_eq("R8", "no mem on forward", 64'(mem_req_valid), 64'd0);
        idle_step(1'b0);
        check_eq("R4", "oldest first", 64'(mem_req_data), 64'h111);
        idle_step(1'b1);
        check_eq("R5", "count after ack", 64'(buf_count), 64'd1);
        idle_step(1'b0);
        check_eq("R10", "gap cycle", 64'(mem_req_valid), 64'd0);
        idle_step(1'b0);
        check_eq("R10", "wb after gap", 64'(mem_req_valid && mem_req_write), 64'd1);
        check_eq("R9", "forwarded line written", 64'(mem_req_data), 64'h222);
        idle_step(1'b1);

        // Overflow: fill with no acks (R3)
        for (int i = 0; i < DEPTH + 1; i++)
            step(1'b1, IDX_W'(i), TAG_W'(i + 9), 64'(i + 64'hA0), 1'b0, '0, '0, 1'b0);
        check_eq("R3", "overflow pulse", 64'(buf_overflow), 64'd1);
        check_eq("R3", "count held", 64'(buf_count), 64'(DEPTH));
        check_eq("R2", "full stall", 64'(buf_full), 64'd1);
        for (int i = 0; i < 40; i++) idle_step(1'b1);
        check_eq("R5", "drained", 64'(buf_count), 64'd0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) < 3, IDX_W'($urandom % 4), TAG_W'($urandom % 4),
                 {$urandom, $urandom},
                 ($urandom % 4) == 0, IDX_W'($urandom % 4), TAG_W'($urandom % 4),
                 ($urandom % 10) < 4);
        end
        compare_all();
        summary();
        $finish;
    end
endmodule